// File: doc/BRIEF.md
# Multi-Queue Shared-Memory FIFO Controller

This block divides one shared data memory into a small set of independent FIFO queues. Each queue owns a contiguous region of the memory made of whole fixed-size blocks. The block count for every queue, together with per-queue almost-full and almost-empty thresholds, is captured from configuration inputs while reset is asserted. Queue regions are packed in queue order from address zero. Each queue keeps its own read pointer, write pointer and occupancy count. Both pointers wrap from the last word of the queue's region back to its first word.

The write port steers each accepted word into the queue named by the write queue select. It reports full and almost-full for that queue only. The read port works in first-word-fall-through style and serves the queue named by the read queue select. It has an output register, an output-valid flag and an almost-empty flag for the selected queue. A read enable consumes the word on display. Moving the read select to another queue never discards data: the displayed word stays at the head of its own queue. A partial reset empties one queue, and it only acts when that queue is selected on both ports.

The whole block runs on one clock with a synchronous active-low reset, which must be held for at least two clock edges. Defaults: 4 queues, 16-word blocks, 64 words of 32 bits.

Top module: `mq_fifo_ctrl`

## Requirements
- R1: Queue q has a depth of 16 × (3-bit block count in cfg_blocks_i[3q+2:3q]) words, and its region starts right after the regions of all lower-numbered queues. With default parameters, exactly that many words can be accepted into an empty queue before full is raised.
- R2: Words written with wr_q_i = q are read back only from queue q and in write order. Traffic on other queues does not disturb them.
- R3: When rd_q_i changes to a non-empty queue, rd_valid_o is low after the first clock edge. After the second edge, rd_valid_o is high and rd_data_o shows that queue's oldest word. The word is held while rd_en_i is low.
- R4: A read enable while rd_valid_o is high consumes the shown word, and the next word (if any) appears after the same edge. Otherwise rd_valid_o falls. A read enable while rd_valid_o is low has no effect. After reset, rd_valid_o and rd_data_o are zero.
- R5: When the read select moves to a queue with no data, rd_valid_o goes low after the next edge and rd_data_o keeps the previous word. An unconsumed word is still delivered when its queue is selected again.
- R6: full_o is high exactly when the occupancy of the write-selected queue equals its depth. A write while full_o is high is dropped.
- R7: afull_o is high when (depth − occupancy) of the write-selected queue is at most that queue's 7-bit threshold cfg_af_i[7q+6:7q].
- R8: aempty_o is high when the occupancy of the read-selected queue is at most its 7-bit threshold cfg_ae_i[7q+6:7q]. The occupancy includes the word on display.
- R9: An accepted write and a read consume on the same queue in the same cycle leave its occupancy unchanged.
- R10: prst_i with wr_q_i equal to rd_q_i empties that queue and drops the cycle's write and consume on it. With different selects, prst_i is ignored.
- R11: Pointers wrap from the last word of a queue's region to its first word, so word order is kept across the wrap.
- R12: A queue with zero blocks always shows full_o high and never produces a valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; configuration captured while low |
| cfg_blocks_i | input | NUM_Q*3 | Block count per queue |
| cfg_af_i | input | NUM_Q*7 | Almost-full threshold per queue (free words) |
| cfg_ae_i | input | NUM_Q*7 | Almost-empty threshold per queue (stored words) |
| wr_en_i | input | 1 | Write request |
| wr_q_i | input | 2 | Write queue select |
| wr_data_i | input | 32 | Write data |
| full_o | output | 1 | Write-selected queue is full |
| afull_o | output | 1 | Write-selected queue is almost full |
| rd_en_i | input | 1 | Consume the displayed word |
| rd_q_i | input | 2 | Read queue select |
| rd_data_o | output | 32 | Output register |
| rd_valid_o | output | 1 | Output register holds an unconsumed word of the current queue |
| aempty_o | output | 1 | Read-selected queue is almost empty |
| prst_i | input | 1 | Partial reset of the queue selected on both ports |

## Verification
A corrupted occupancy count shows at once in the combinational full, almost-full and almost-empty flags of the selected queue. It also shows when draining, because rd_valid_o ends one word early or late. A wrong pointer or base shows as a wrong or out-of-order word on rd_data_o on the first read after the fault. For wrap errors, that is after the queue's depth of traffic. A broken output stage shows within two edges of a select change, as a valid word that arrives too early, is lost, or replaces the word held on the output.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int unsigned MQ_NUM_Q     = 4;
    localparam int unsigned MQ_BLK_WORDS = 16;
    localparam int unsigned MQ_MEM_WORDS = 64;
    localparam int unsigned MQ_DATA_W    = 32;

    typedef struct packed {
        logic full;
        logic afull;
    } mq_wr_flags_t;
endpackage

// File: rtl/mq_cfg_table.sv
module mq_cfg_table #(
    parameter int unsigned NUM_Q     = 4,
    parameter int unsigned BLK_WORDS = 16,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned CNT_W     = 7,
    parameter int unsigned BCNT_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_Q*BCNT_W-1:0]           blocks_i,
    input  logic [NUM_Q*CNT_W-1:0]            af_i,
    input  logic [NUM_Q*CNT_W-1:0]            ae_i,
    output logic [NUM_Q-1:0][ADDR_W-1:0]      base_o,
    output logic [NUM_Q-1:0][ADDR_W-1:0]      last_o,
    output logic [NUM_Q-1:0][CNT_W-1:0]       depth_o,
    output logic [NUM_Q-1:0][CNT_W-1:0]       af_o,
    output logic [NUM_Q-1:0][CNT_W-1:0]       ae_o
);
    localparam int unsigned BLK_LG = $clog2(BLK_WORDS);

    typedef struct packed {
        logic [NUM_Q*BCNT_W-1:0] blocks;
        logic [NUM_Q*CNT_W-1:0]  af;
        logic [NUM_Q*CNT_W-1:0]  ae;
    } cfg_t;

    cfg_t            cfg_d, cfg_q;
    logic [CNT_W:0]  acc_c;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.blocks = blocks_i;
            cfg_d.af     = af_i;
            cfg_d.ae     = ae_i;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    // regions are packed in queue order; last = base + depth - 1
    always_comb begin
        acc_c = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            depth_o[q] = CNT_W'(cfg_q.blocks[q*BCNT_W +: BCNT_W]) << BLK_LG;
            base_o[q]  = acc_c[ADDR_W-1:0];
            last_o[q]  = ADDR_W'(acc_c + (CNT_W+1)'(depth_o[q]) - (CNT_W+1)'(1));
            acc_c      = acc_c + (CNT_W+1)'(depth_o[q]);
            af_o[q]    = cfg_q.af[q*CNT_W +: CNT_W];
            ae_o[q]    = cfg_q.ae[q*CNT_W +: CNT_W];
        end
    end
endmodule

// File: rtl/mq_queue_state.sv
module mq_queue_state #(
    parameter int unsigned NUM_Q  = 4,
    parameter int unsigned QW     = 2,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned CNT_W  = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_Q-1:0][ADDR_W-1:0] base_i,
    input  logic [NUM_Q-1:0][ADDR_W-1:0] last_i,
    input  logic [NUM_Q-1:0][CNT_W-1:0]  depth_i,
    input  logic                         push_i,
    input  logic [QW-1:0]                push_q_i,
    input  logic                         pop_i,
    input  logic [QW-1:0]                pop_q_i,
    input  logic                         clr_i,
    input  logic [QW-1:0]                clr_q_i,
    output logic [NUM_Q-1:0][ADDR_W-1:0] rptr_o,
    output logic [NUM_Q-1:0][ADDR_W-1:0] wptr_o,
    output logic [NUM_Q-1:0][CNT_W-1:0]  cnt_o
);
    typedef struct packed {
        logic [NUM_Q-1:0][ADDR_W-1:0] rptr;
        logic [NUM_Q-1:0][ADDR_W-1:0] wptr;
        logic [NUM_Q-1:0][CNT_W-1:0]  cnt;
    } qst_t;

    qst_t st_d, st_q;

    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p,
                                                   input logic [ADDR_W-1:0] b,
                                                   input logic [ADDR_W-1:0] l);
        return (p == l) ? b : p + ADDR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        for (int q = 0; q < NUM_Q; q++) begin
            if (!rst_n || (clr_i && clr_q_i == QW'(q))) begin
                st_d.rptr[q] = base_i[q];
                st_d.wptr[q] = base_i[q];
                st_d.cnt[q]  = '0;
            end else begin
                if (push_i && push_q_i == QW'(q))
                    st_d.wptr[q] = step_ptr(st_q.wptr[q], base_i[q], last_i[q]);
                if (pop_i && pop_q_i == QW'(q))
                    st_d.rptr[q] = step_ptr(st_q.rptr[q], base_i[q], last_i[q]);
                if ((push_i && push_q_i == QW'(q)) && !(pop_i && pop_q_i == QW'(q)))
                    st_d.cnt[q] = st_q.cnt[q] + CNT_W'(1);
                else if (!(push_i && push_q_i == QW'(q)) && (pop_i && pop_q_i == QW'(q)))
                    st_d.cnt[q] = st_q.cnt[q] - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rptr_o = st_q.rptr;
    assign wptr_o = st_q.wptr;
    assign cnt_o  = st_q.cnt;

    for (genvar g = 0; g < NUM_Q; g++) begin : gen_chk
        // R6
        cnt_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[g] <= depth_i[g]);
        // R9
        same_q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (push_i && pop_i && push_q_i == QW'(g) && pop_q_i == QW'(g) && !clr_i)
            |=> $stable(st_q.cnt[g]));
        // R10
        clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && clr_q_i == QW'(g))
            |=> (st_q.cnt[g] == '0 && st_q.rptr[g] == st_q.wptr[g]));
    end
endmodule

// File: rtl/mq_read_stage.sv
module mq_read_stage #(
    parameter int unsigned QW     = 2,
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QW-1:0]     rd_q_i,
    input  logic              rd_en_i,
    input  logic [CNT_W-1:0]  cnt_cur_i,
    input  logic              kill_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [QW-1:0]     cur_q_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              consume_o
);
    typedef struct packed {
        logic [QW-1:0]     cur;
        logic              ov;
        logic [DATA_W-1:0] dout;
    } rst_t;

    rst_t st_d, st_q;

    assign consume_o = rd_en_i & st_q.ov;

    // the displayed word stays counted in its queue until consumed
    always_comb begin
        st_d      = st_q;
        st_d.cur  = rd_q_i;
        st_d.ov   = (rd_q_i == st_q.cur) && !kill_i && (cnt_cur_i != CNT_W'(consume_o));
        st_d.dout = st_d.ov ? word_i : st_q.dout;
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cur_q_o = st_q.cur;
    assign valid_o = st_q.ov;
    assign data_o  = st_q.dout;

    // R5
    switch_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q_i != st_q.cur) |=> !st_q.ov);
    // R5
    stale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ov |-> $stable(st_q.dout));
endmodule

// File: rtl/mq_fifo_ctrl.sv
module mq_fifo_ctrl
    import mq_pkg::*;
#(
    parameter int unsigned NUM_Q     = MQ_NUM_Q,
    parameter int unsigned BLK_WORDS = MQ_BLK_WORDS,
    parameter int unsigned MEM_WORDS = MQ_MEM_WORDS,
    parameter int unsigned DATA_W    = MQ_DATA_W,
    localparam int unsigned NBLK     = MEM_WORDS / BLK_WORDS,
    localparam int unsigned QW       = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int unsigned ADDR_W   = $clog2(MEM_WORDS),
    localparam int unsigned CNT_W    = $clog2(MEM_WORDS + 1),
    localparam int unsigned BCNT_W   = $clog2(NBLK + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_Q*BCNT_W-1:0] cfg_blocks_i,
    input  logic [NUM_Q*CNT_W-1:0]  cfg_af_i,
    input  logic [NUM_Q*CNT_W-1:0]  cfg_ae_i,
    input  logic                    wr_en_i,
    input  logic [QW-1:0]           wr_q_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    output logic                    full_o,
    output logic                    afull_o,
    input  logic                    rd_en_i,
    input  logic [QW-1:0]           rd_q_i,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic                    rd_valid_o,
    output logic                    aempty_o,
    input  logic                    prst_i
);
    logic [NUM_Q-1:0][ADDR_W-1:0] base, last, rptr, wptr;
    logic [NUM_Q-1:0][CNT_W-1:0]  depth, af_thr, ae_thr, cnt;
    logic [DATA_W-1:0]            mem_q [MEM_WORDS];
    logic [QW-1:0]                cur_q;
    logic                         clr, push, consume, kill;
    logic [ADDR_W-1:0]            rptr_nxt;
    mq_wr_flags_t                 wflags;

    mq_cfg_table #(.NUM_Q(NUM_Q), .BLK_WORDS(BLK_WORDS), .ADDR_W(ADDR_W),
                   .CNT_W(CNT_W), .BCNT_W(BCNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .blocks_i(cfg_blocks_i), .af_i(cfg_af_i), .ae_i(cfg_ae_i),
        .base_o(base), .last_o(last), .depth_o(depth), .af_o(af_thr), .ae_o(ae_thr));

    mq_queue_state #(.NUM_Q(NUM_Q), .QW(QW), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_qst (
        .clk(clk), .rst_n(rst_n), .base_i(base), .last_i(last), .depth_i(depth),
        .push_i(push), .push_q_i(wr_q_i), .pop_i(consume), .pop_q_i(cur_q),
        .clr_i(clr), .clr_q_i(wr_q_i), .rptr_o(rptr), .wptr_o(wptr), .cnt_o(cnt));

    mq_read_stage #(.QW(QW), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_q_i(rd_q_i), .rd_en_i(rd_en_i),
        .cnt_cur_i(cnt[cur_q]), .kill_i(kill), .word_i(mem_q[rptr_nxt]),
        .cur_q_o(cur_q), .valid_o(rd_valid_o), .data_o(rd_data_o), .consume_o(consume));

    always_comb begin
        wflags.full  = cnt[wr_q_i] >= depth[wr_q_i];
        wflags.afull = (depth[wr_q_i] - cnt[wr_q_i]) <= af_thr[wr_q_i];
        full_o       = wflags.full;
        afull_o      = wflags.afull;
        aempty_o     = cnt[rd_q_i] <= ae_thr[rd_q_i];
        clr          = prst_i && (wr_q_i == rd_q_i);
        push         = wr_en_i && !wflags.full;
        kill         = clr && (rd_q_i == cur_q);
        rptr_nxt     = rptr[cur_q];
        if (consume)
            rptr_nxt = (rptr[cur_q] == last[cur_q]) ? base[cur_q] : rptr[cur_q] + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wptr[wr_q_i]] <= wr_data_i;
    end

    // R4
    valid_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> cnt[cur_q] != '0);
    // R12
    empty_region_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (depth[cur_q] == '0) |-> !rd_valid_o);
endmodule

// File: tb/mq_fifo_ctrl_tb.sv
module mq_fifo_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] cfg_blocks;
    logic [27:0] cfg_af, cfg_ae;
    logic        wr_en, rd_en, prst;
    logic [1:0]  wr_q, rd_q;
    logic [31:0] din;
    logic        full, afull, aempty, rd_valid;
    logic [31:0] rd_data;
    int          total = 0;
    int          bad   = 0;

    always #5 clk = ~clk;

    mq_fifo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_blocks_i(cfg_blocks), .cfg_af_i(cfg_af), .cfg_ae_i(cfg_ae),
        .wr_en_i(wr_en), .wr_q_i(wr_q), .wr_data_i(din), .full_o(full), .afull_o(afull),
        .rd_en_i(rd_en), .rd_q_i(rd_q), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
        .aempty_o(aempty), .prst_i(prst));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_words(input int q, input logic [31:0] first, input int n);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1; wr_q = 2'(q); din = first + 32'(i);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic read_seq(input string tag, input int q, input logic [31:0] first,
                            input int n, input int cnt0, input int thr);
        rd_q = 2'(q); rd_en = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < n; i++) begin
            chk({tag, " valid"}, 32'(rd_valid), 32'd1);
            chk({tag, " data"}, rd_data, first + 32'(i));
            chk({tag, " aempty R8"}, 32'(aempty), 32'((cnt0 - i) <= thr));
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk({tag, " drained valid"}, 32'(rd_valid), 32'd0);
        chk({tag, " held data"}, rd_data, first + 32'(n - 1));
    endtask

    task automatic t_reset();
        chk("R4 reset valid", 32'(rd_valid), 32'd0);
        chk("R4 reset data", rd_data, 32'd0);
        chk("R6 reset full q0", 32'(full), 32'd0);
        chk("R7 reset afull q0", 32'(afull), 32'd0);
        chk("R8 reset aempty q0", 32'(aempty), 32'd1);
    endtask

    task automatic t_fill_q0();
        rd_q = 2'd1; wr_q = 2'd0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            chk("R7 afull while filling q0", 32'(afull), 32'((16 - i) <= 2));
            chk("R1/R6 not full below depth", 32'(full), 32'd0);
            wr_en = 1'b1; din = 32'h100 + 32'(i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R1/R6 full at 16 words", 32'(full), 32'd1);
        chk("R7 afull at 16 words", 32'(afull), 32'd1);
        wr_en = 1'b1; din = 32'hDEAD;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 still full after dropped write", 32'(full), 32'd1);
        rd_q = 2'd0;
        @(negedge clk);
        chk("R3 not valid one clock after select", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R3 valid two clocks after select", 32'(rd_valid), 32'd1);
        chk("R3 first word falls through", rd_data, 32'h100);
        @(negedge clk);
        chk("R3 word held without read enable", rd_data, 32'h100);
        read_seq("R6 drain q0 no extra word", 0, 32'h100, 16, 16, 1);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R4 read while invalid ignored valid", 32'(rd_valid), 32'd0);
        chk("R4 read while invalid ignored data", rd_data, 32'h10F);
        write_words(0, 32'h1AA, 1);
        read_seq("R4 next word after idle read", 0, 32'h1AA, 1, 1, 1);
    endtask

    task automatic t_zero_q();
        wr_q = 2'd2;
        @(negedge clk);
        chk("R12 zero-block queue full", 32'(full), 32'd1);
        chk("R12 zero-block queue afull", 32'(afull), 32'd1);
        wr_en = 1'b1; din = 32'hBAD;
        @(negedge clk);
        wr_en = 1'b0; rd_q = 2'd2;
        repeat (3) @(negedge clk);
        chk("R12 zero-block queue never valid", 32'(rd_valid), 32'd0);
        chk("R12 zero-block queue still full", 32'(full), 32'd1);
    endtask

    task automatic t_switch();
        write_words(0, 32'hA0, 1);
        write_words(1, 32'hB0, 1);
        rd_q = 2'd1;
        @(negedge clk); @(negedge clk);
        chk("R5 shown word before switch", rd_data, 32'hB0);
        rd_q = 2'd2;
        @(negedge clk);
        chk("R5 switch to empty drops valid", 32'(rd_valid), 32'd0);
        chk("R5 switch to empty keeps data", rd_data, 32'hB0);
        repeat (3) @(negedge clk);
        chk("R5 stale word still held", rd_data, 32'hB0);
        read_seq("R5 unconsumed word not lost", 1, 32'hB0, 1, 1, 3);
        read_seq("R5 other queue intact", 0, 32'hA0, 1, 1, 1);
    endtask

    task automatic t_interleave();
        for (int i = 0; i < 4; i++) begin
            write_words(0, 32'h800 + 32'(i), 1);
            write_words(1, 32'h900 + 32'(i), 1);
        end
        read_seq("R2 queue 1 order", 1, 32'h900, 4, 4, 3);
        read_seq("R2 queue 0 order", 0, 32'h800, 4, 4, 1);
    endtask

    task automatic t_same_q();
        write_words(1, 32'h300, 3);
        rd_q = 2'd1;
        @(negedge clk); @(negedge clk);
        chk("R9 head before overlap", rd_data, 32'h300);
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1; wr_q = 2'd1; din = 32'h303 + 32'(i); rd_en = 1'b1;
            @(negedge clk);
            chk("R9 overlap data", rd_data, 32'h301 + 32'(i));
            chk("R9 overlap valid", 32'(rd_valid), 32'd1);
            chk("R9 overlap occupancy (aempty)", 32'(aempty), 32'd1);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        read_seq("R9 occupancy unchanged tail", 1, 32'h304, 3, 3, 3);
    endtask

    task automatic t_wrap();
        write_words(3, 32'h500, 10);
        read_seq("R11 first pass", 3, 32'h500, 10, 10, 0);
        write_words(3, 32'h600, 16);
        wr_q = 2'd3;
        @(negedge clk);
        chk("R11 full after wrap fill", 32'(full), 32'd1);
        read_seq("R11 order across wrap", 3, 32'h600, 16, 16, 0);
    endtask

    task automatic t_prst();
        write_words(3, 32'h700, 3);
        wr_q = 2'd3; rd_q = 2'd0; prst = 1'b1;
        @(negedge clk);
        prst = 1'b0;
        read_seq("R10 differing selects ignored", 3, 32'h700, 3, 3, 0);
        write_words(3, 32'h710, 3);
        rd_q = 2'd3;
        @(negedge clk); @(negedge clk);
        chk("R10 head before clear", rd_data, 32'h710);
        wr_q = 2'd3; prst = 1'b1;
        @(negedge clk);
        prst = 1'b0;
        chk("R10 clear drops valid", 32'(rd_valid), 32'd0);
        chk("R10 clear keeps output data", rd_data, 32'h710);
        chk("R10 cleared queue aempty", 32'(aempty), 32'd1);
        chk("R10 cleared queue not full", 32'(full), 32'd0);
        write_words(3, 32'h720, 1);
        read_seq("R10 queue restarts empty", 3, 32'h720, 1, 1, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; prst = 1'b0;
        wr_q = 2'd0; rd_q = 2'd0; din = '0;
        cfg_blocks = {3'd1, 3'd0, 3'd2, 3'd1};
        cfg_af     = {7'd1, 7'd0, 7'd4, 7'd2};
        cfg_ae     = {7'd0, 7'd0, 7'd3, 7'd1};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_q0();
        t_zero_q();
        t_switch();
        t_interleave();
        t_same_q();
        t_wrap();
        t_prst();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule